// File: doc/BRIEF.md
# I2C Bus Timing Watchdog

This block is a single 10-bit timer that sits beside an I2C engine and serves two purposes at once. Its three low-order bits produce a "minimum interval elapsed" flag. The engine uses this flag to pace setup and hold times on the bus, and the required interval depends on a 2-bit speed select. The full width of the counter detects a bus that has stopped moving during a transfer. If neither a clock transition nor a start or stop condition is seen for a timeout period, the block raises a sticky hang flag that serves as an interrupt request.

The operating mode comes from three interface enable inputs and a run bit:

- **Off.** With every enable low, the timer is held at zero and the run bit does nothing.
- **Interval only.** With any enable high and the run bit low, only the low bits count. The upper bits stay at zero, so no hang check is made.
- **Full.** With any enable high and the run bit high, the whole counter runs while a frame is open, from a start condition until a stop condition.

The raw SCL line goes through a two-flop synchronizer and an edge detector before it restarts the timer.

On every restart, the low bits are preloaded to 8 minus the selected interval N. This makes the interval flag rise exactly N cycles later. It also makes the full counter roll over exactly 1016 + N cycles after the restart, which gives timeouts of 1020 to 1023 cycles.

Top module: `i2c_wdt`

## Requirements
- R1: With en_slave, en_mreq and en_master all 0, min_elapsed stays 0 and hang_irq never sets, whatever the value of tmr_run.
- R2: With any enable high, min_elapsed rises exactly N cycles after a restart and holds until the next restart. N is 7 for spd_sel=2'b10, 6 for 2'b01, 5 for 2'b00 and 4 for 2'b11.
- R3: With any enable high and tmr_run=0, hang_irq never sets, however long the bus stays idle.
- R4: With any enable high and tmr_run=1, hang_irq sets exactly T cycles after a start condition if nothing else happens in between. T is 1023 for spd_sel=2'b10, 1022 for 2'b01, 1021 for 2'b00 and 1020 for 2'b11.
- R5: A level change on scl_in restarts the timer on the third rising clock edge after the change. min_elapsed falls after that edge and rises again N edges later.
- R6: A start_det or stop_det pulse restarts the timer at the edge where it is sampled. A stop closes the frame, so no hang check is made after it, while the interval bits keep running.
- R7: SCL transitions spaced closer than the timeout period keep hang_irq at 0 indefinitely.
- R8: hang_irq is sticky. Once set, it stays set through SCL edges, stop conditions and elapsed time, until a hang_clr pulse clears it at the next edge.
- R9: While rst_n is low at a rising edge, both outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_slave | input | 1 | Interface enable: slave role |
| en_mreq | input | 1 | Interface enable: master requested |
| en_master | input | 1 | Interface enable: master role active |
| tmr_run | input | 1 | Run bit: enables hang checking when an interface enable is set |
| spd_sel | input | 2 | Speed select choosing interval N and timeout T |
| scl_in | input | 1 | Raw SCL line level (asynchronous) |
| start_det | input | 1 | One-cycle start condition pulse |
| stop_det | input | 1 | One-cycle stop condition pulse |
| hang_clr | input | 1 | One-cycle clear of the hang flag |
| min_elapsed | output | 1 | Minimum interval since the last restart has elapsed |
| hang_irq | output | 1 | Sticky bus-hang flag and interrupt request |

## Verification
The timing of each result is counted in rising edges from the stimulus:

| Result | Due after |
|---|---|
| min_elapsed after a start or stop pulse | N edges past the edge that samples the pulse |
| min_elapsed after a change on scl_in | 3 + N edges |
| hang_irq after a start with no other activity | 1016 + N edges |
| clearing hang_irq with hang_clr | 1 edge |

The bench drives every input on the falling edge and samples on the next falling edge, so each sample follows exactly one known rising edge. The table loop records the first edge index at which each output rises and compares that index with N or T. The directed tests sample just before and just after each predicted edge, so a result that is one cycle early or late is reported.

// File: rtl/i2c_wdt_pkg.sv
// Package: shared types and the speed-select decode for the I2C bus watchdog.
// Assumes a 2-bit speed select; the interval table lives only here.
package i2c_wdt_pkg;

    // Operating mode derived from the interface enables and the run bit.
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_MIN  = 2'd1,
        MODE_FULL = 2'd2
    } wdt_mode_e;

    // Minimum-interval length in cycles for a given speed select.
    function automatic int unsigned min_cycles(input logic [1:0] sel);
        int unsigned n;
        case (sel)
            2'b10:   n = 7;
            2'b01:   n = 6;
            2'b00:   n = 5;
            default: n = 4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/i2c_wdt_sync.sv
// Module: multi-stage synchronizer with a change detector for the SCL level.
// Assumes STAGES >= 2 and an idle-high line; toggle pulses for one cycle
// after a new level reaches the last synchronizer stage.
module i2c_wdt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic toggle
);

    logic [STAGES-1:0] pipe;
    logic              last;

    // Shift the raw level through the synchronizer and remember the prior level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
            last <= RST_VAL;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            last <= pipe[STAGES-1];
        end
    end

    assign dout   = pipe[STAGES-1];
    assign toggle = pipe[STAGES-1] ^ last;

endmodule

// File: rtl/i2c_wdt_ctl.sv
// Module: mode decode, frame tracking and restart generation.
// Assumes start/stop detect inputs are single-cycle pulses in this clock domain.
module i2c_wdt_ctl
    import i2c_wdt_pkg::*;
#(
    parameter int N_EN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EN-1:0] if_en,
    input  logic            run,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic            scl_toggle,
    output wdt_mode_e       mode,
    output logic            active,
    output logic            restart,
    output logic            hang_chk
);

    logic in_frame;

    // Decode the operating mode from the enables and the run bit.
    always_comb begin
        if (if_en == '0)
            mode = MODE_OFF;
        else if (run)
            mode = MODE_FULL;
        else
            mode = MODE_MIN;
    end

    // Track whether a bus frame is open: start opens, stop closes, off resets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_frame <= 1'b0;
        else if (mode == MODE_OFF)
            in_frame <= 1'b0;
        else if (start_det)
            in_frame <= 1'b1;
        else if (stop_det)
            in_frame <= 1'b0;
    end

    // Any bus event restarts the timer while an interface is enabled.
    always_comb begin
        active   = (mode != MODE_OFF);
        restart  = active && (start_det || stop_det || scl_toggle);
        hang_chk = (mode == MODE_FULL) && in_frame;
    end

endmodule

// File: rtl/i2c_wdt_cnt.sv
// Module: split counter. Low bits time the minimum interval after a preload,
// high bits extend the range for hang detection only while hang_chk is high.
// Assumes LOW_W is wide enough that 2**LOW_W exceeds the largest interval.
module i2c_wdt_cnt
    import i2c_wdt_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int LOW_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       restart,
    input  logic       hang_chk,
    input  logic [1:0] sel,
    output logic       min_done,
    output logic       overflow
);

    localparam int          HI_W    = CNT_W - LOW_W;
    localparam int unsigned LO_SPAN = 1 << LOW_W;

    logic [LOW_W-1:0] lo;
    logic [HI_W-1:0]  hi;
    logic [LOW_W-1:0] preload;
    logic             lo_wrap;
    logic             hi_wrap;

    // Preload so that the low bits wrap after exactly the selected interval.
    always_comb begin
        preload = LOW_W'(LO_SPAN - min_cycles(sel));
        lo_wrap = &lo;
        hi_wrap = &hi;
        overflow = hang_chk && !restart && lo_wrap && hi_wrap;
    end

    // Low bits: cleared when off, preloaded on restart, otherwise free-running.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            lo <= '0;
        else if (restart)
            lo <= preload;
        else
            lo <= lo + 1'b1;
    end

    // High bits: idle at zero unless hang checking, then take the low carry.
    always_ff @(posedge clk) begin
        if (!rst_n || !hang_chk || restart)
            hi <= '0;
        else if (lo_wrap)
            hi <= hi + 1'b1;
    end

    // Interval flag: set on the first low-bit wrap after a restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || restart)
            min_done <= 1'b0;
        else if (lo_wrap)
            min_done <= 1'b1;
    end

endmodule

// File: rtl/i2c_wdt_flag.sv
// Module: sticky event flag; a set takes precedence over a clear in one cycle.
// Assumes clr is a single-cycle software write pulse.
module i2c_wdt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Hold the flag from the set until an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

endmodule

// File: rtl/i2c_wdt.sv
// Module: I2C bus timing watchdog top. Combines SCL synchronization, mode
// control, the split interval/hang counter and the sticky hang flag.
// Assumes start_det/stop_det/hang_clr are synchronous one-cycle pulses.
module i2c_wdt
    import i2c_wdt_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int LOW_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_slave,
    input  logic       en_mreq,
    input  logic       en_master,
    input  logic       tmr_run,
    input  logic [1:0] spd_sel,
    input  logic       scl_in,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       hang_clr,
    output logic       min_elapsed,
    output logic       hang_irq
);

    localparam int N_EN = 3;

    logic            scl_sync;
    logic            scl_toggle;
    logic [N_EN-1:0] if_en;
    wdt_mode_e       mode;
    logic            active;
    logic            restart;
    logic            hang_chk;
    logic            overflow;

    assign if_en = {en_master, en_mreq, en_slave};

    i2c_wdt_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (scl_in),
        .dout   (scl_sync),
        .toggle (scl_toggle)
    );

    i2c_wdt_ctl #(
        .N_EN (N_EN)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .if_en      (if_en),
        .run        (tmr_run),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .scl_toggle (scl_toggle),
        .mode       (mode),
        .active     (active),
        .restart    (restart),
        .hang_chk   (hang_chk)
    );

    i2c_wdt_cnt #(
        .CNT_W (CNT_W),
        .LOW_W (LOW_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .restart  (restart),
        .hang_chk (hang_chk),
        .sel      (spd_sel),
        .min_done (min_elapsed),
        .overflow (overflow)
    );

    i2c_wdt_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (overflow),
        .clr   (hang_clr),
        .flag  (hang_irq)
    );

    // The synchronized level itself is only needed for its change detect.
    logic unused_ok;
    assign unused_ok = scl_sync ^ (mode == MODE_MIN);

endmodule

// File: rtl/i2c_wdt_chk.sv
// Module: property checker for the I2C bus watchdog, bound to the top.
// Assumes the same clock and synchronous active-low reset as the design.
module i2c_wdt_chk (
    input logic clk,
    input logic rst_n,
    input logic any_en,
    input logic tmr_run,
    input logic start_det,
    input logic stop_det,
    input logic scl_toggle,
    input logic hang_clr,
    input logic min_elapsed,
    input logic hang_irq
);

    p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |=> !min_elapsed);

    p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (any_en && min_elapsed && !start_det && !stop_det && !scl_toggle) |=> min_elapsed);

    p_no_hang_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_run && !hang_irq) |=> !hang_irq);

    p_scl_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_en && scl_toggle) |=> !min_elapsed);

    p_evt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_en && (start_det || stop_det)) |=> !min_elapsed);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hang_irq && !hang_clr) |=> hang_irq);

endmodule

bind i2c_wdt i2c_wdt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_en      (en_slave | en_mreq | en_master),
    .tmr_run     (tmr_run),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .scl_toggle  (scl_toggle),
    .hang_clr    (hang_clr),
    .min_elapsed (min_elapsed),
    .hang_irq    (hang_irq)
);

// File: tb/sim_i2c_wdt.sv
// Bench: table-driven mode/speed sweep, then directed restart, sticky and reset tests.
module sim_i2c_wdt;

    localparam int CLK_PERIOD = 10;
    localparam int SPAN       = 1100;
    localparam int NVEC       = 8;

    typedef struct packed {
        logic [2:0]  en;
        logic        run;
        logic [1:0]  sel;
        logic [3:0]  exp_min;
        logic [10:0] exp_tmo;
    } vec_t;

    // exp_min/exp_tmo of 0 mean the output must not rise within SPAN cycles.
    localparam vec_t VECS [NVEC] = '{
        '{3'b001, 1'b1, 2'b10, 4'd7, 11'd1023},
        '{3'b010, 1'b1, 2'b01, 4'd6, 11'd1022},
        '{3'b100, 1'b1, 2'b00, 4'd5, 11'd1021},
        '{3'b111, 1'b1, 2'b11, 4'd4, 11'd1020},
        '{3'b001, 1'b0, 2'b10, 4'd7, 11'd0},
        '{3'b100, 1'b0, 2'b11, 4'd4, 11'd0},
        '{3'b000, 1'b1, 2'b00, 4'd0, 11'd0},
        '{3'b000, 1'b0, 2'b01, 4'd0, 11'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_slave = 1'b0, en_mreq = 1'b0, en_master = 1'b0;
    logic       tmr_run = 1'b0;
    logic [1:0] spd_sel = 2'b00;
    logic       scl_in = 1'b1;
    logic       start_det = 1'b0, stop_det = 1'b0, hang_clr = 1'b0;
    logic       min_elapsed, hang_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_wdt u0 (
        .clk(clk), .rst_n(rst_n), .en_slave(en_slave), .en_mreq(en_mreq),
        .en_master(en_master), .tmr_run(tmr_run), .spd_sel(spd_sel),
        .scl_in(scl_in), .start_det(start_det), .stop_det(stop_det),
        .hang_clr(hang_clr), .min_elapsed(min_elapsed), .hang_irq(hang_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] en, input logic run, input logic [1:0] sel);
        @(negedge clk);
        {en_master, en_mreq, en_slave} = en;
        tmr_run = run;
        spd_sel = sel;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) start_det = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_det = 1'b1;
        @(negedge clk) stop_det = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) hang_clr = 1'b1;
        @(negedge clk) hang_clr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state.
        wait_cyc(3);
        chk("R9 reset min_elapsed", int'(min_elapsed), 0);
        chk("R9 reset hang_irq", int'(hang_irq), 0);
        @(negedge clk) rst_n = 1'b1;

        // Table sweep: R1, R2, R3, R4.
        for (int v = 0; v < NVEC; v++) begin
            int first_min;
            int first_tmo;
            cfg(VECS[v].en, VECS[v].run, VECS[v].sel);
            pulse_stop();
            pulse_clr();
            pulse_start();
            first_min = 0;
            first_tmo = 0;
            for (int k = 1; k <= SPAN; k++) begin
                @(negedge clk);
                if (min_elapsed && first_min == 0) first_min = k;
                if (hang_irq && first_tmo == 0) first_tmo = k;
            end
            if (VECS[v].en == 3'b000) begin
                chk("R1 off: interval flag", first_min, 0);
                chk("R1 off: hang flag", first_tmo, 0);
            end else begin
                chk("R2 interval length", first_min, int'(VECS[v].exp_min));
                if (VECS[v].run)
                    chk("R4 timeout period", first_tmo, int'(VECS[v].exp_tmo));
                else
                    chk("R3 no hang check", first_tmo, 0);
            end
            pulse_stop();
            pulse_clr();
        end

        // R5: SCL change restarts on the third edge, then N=7 more.
        cfg(3'b001, 1'b1, 2'b10);
        pulse_start();
        wait_cyc(10);
        @(negedge clk) scl_in = ~scl_in;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k == 2)  chk("R5 before restart edge", int'(min_elapsed), 1);
            if (k == 3)  chk("R5 restart edge", int'(min_elapsed), 0);
            if (k == 9)  chk("R5 one edge early", int'(min_elapsed), 0);
            if (k == 10) chk("R5 interval after SCL", int'(min_elapsed), 1);
        end

        // R6: start restarts; stop restarts and ends hang checking.
        pulse_start();
        chk("R6 start restart", int'(min_elapsed), 0);
        wait_cyc(10);
        pulse_stop();
        chk("R6 stop restart", int'(min_elapsed), 0);
        wait_cyc(7);
        chk("R6 interval runs after stop", int'(min_elapsed), 1);
        wait_cyc(SPAN);
        chk("R6 no hang after stop", int'(hang_irq), 0);

        // R7: periodic SCL activity keeps the hang flag clear.
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            wait_cyc(600);
            @(negedge clk) scl_in = ~scl_in;
        end
        wait_cyc(10);
        chk("R7 no hang with SCL activity", int'(hang_irq), 0);

        // R8: sticky flag until clear.
        pulse_start();
        wait_cyc(SPAN);
        chk("R8 hang set", int'(hang_irq), 1);
        @(negedge clk) scl_in = ~scl_in;
        pulse_stop();
        wait_cyc(50);
        chk("R8 hang stays set", int'(hang_irq), 1);
        pulse_clr();
        chk("R8 hang cleared", int'(hang_irq), 0);

        // R9: reset during operation.
        pulse_start();
        wait_cyc(SPAN);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset clears hang", int'(hang_irq), 0);
        chk("R9 reset clears interval", int'(min_elapsed), 0);
        @(negedge clk) rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule